// File: doc/BRIEF.md
# Inbound Mailbox with Has-Data Interrupt

This block is a word-wide inbound mailbox. A producer pushes 32-bit message words into a small FIFO through a dedicated push port. A host CPU drains them through a register window on a simple memory-mapped bus.

The host has four views of the mailbox:
- a destructive data port that hands over the oldest word and removes it;
- a peek port that shows the oldest word and leaves it in place;
- a status word carrying separate full and empty flags;
- a configuration word holding an interrupt enable and a has-data pending flag.

A single level interrupt tells the host that words are waiting, provided software has enabled it. Reading an empty mailbox never stalls the bus. It returns a fixed invalid-data marker, and slots that hold no message always contain that marker. The producer sees the full flag on its own port and must hold off while it is high.

Bus reads return their data one cycle after the request. Only whole-word accesses, with all four byte enables set, are acted upon. Only the low eight address bits take part in decoding.

Top module: `inbox_mailbox`

## Requirements
- R1: A whole-word read at offset 0x80, 0x84, 0x88 or 0x8C of a non-empty mailbox returns the oldest word and removes it. Words come out in the order they were pushed. A push and such a read in the same cycle both take effect.
- R2: A read at any of those pop offsets while the mailbox is empty returns MARKER (default 32'hFFFF_FFFF) and leaves the mailbox empty.
- R3: A read at offset 0x90 returns the oldest word without removing it. A later pop returns the same word.
- R4: The status word at offset 0x98 has bit 31 set exactly when the entry count equals DEPTH and bit 30 set exactly when the count is zero. All other bits read 0.
- R5: The config word is at offset 0x9C. Bit 0 is the interrupt enable, and a write changes only bit 0. Bit 4 reads 1 whenever the mailbox is not empty. All other bits read 0.
- R6: `irq` is high exactly when the mailbox is not empty and the enable bit is 1. It follows a push, a pop or a config write in the cycle after the bus or push edge.
- R7: After reset the mailbox is empty, the enable is 0 and every slot holds MARKER. A peek after reset returns MARKER, and so does a peek after the last word has been popped.
- R8: Address bits above bit 7 are ignored: offset 0x184 acts exactly like 0x84.
- R9: An access whose byte enables are not all 1 has no effect. A read of that kind returns 0 and pops nothing.
- R10: A read at any other low-byte offset, including unaligned ones such as 0x81, returns 0 and changes nothing. Writes there are ignored.
- R11: A push while the count equals DEPTH is dropped, even when a pop happens in the same cycle. The `full` output is high exactly when the count equals DEPTH.
- R12: `rd_valid` is high, with `rd_data`, in the cycle after each read request, whether or not the request was acted upon.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (12) | Byte address; low 8 bits decoded |
| req_be | input | 4 | Byte enables; all four must be set |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after request) |
| rd_data | output | 32 | Read data |
| push_valid | input | 1 | Producer push strobe |
| push_data | input | 32 | Word to push |
| full | output | 1 | Mailbox holds DEPTH words |
| irq | output | 1 | Has-data interrupt, level |

## Verification
Each bus read is sampled on the falling edge that follows the rising edge that accepted it, because `rd_data` is one register past the request. Pushes, pops and config writes are judged from `full`, `irq` and later status, config and peek reads, all sampled on that same falling edge; both the count and the enable settle on the accepting edge. The vector table issues one request per cycle, so a read always shows the effect of every earlier row and of none of the later ones. The directed tests then cover a fill to DEPTH, a dropped push, a push in the same cycle as a pop, interrupt gating, and reset in the middle of a run.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam logic [7:0] OFF_POP_FIRST = 8'h80;
  localparam logic [7:0] OFF_POP_LAST  = 8'h8C;
  localparam logic [7:0] OFF_PEEK      = 8'h90;
  localparam logic [7:0] OFF_STATUS    = 8'h98;
  localparam logic [7:0] OFF_CONFIG    = 8'h9C;

  localparam int STAT_FULL_BIT  = 31;
  localparam int STAT_EMPTY_BIT = 30;
  localparam int CFG_EN_BIT     = 0;
  localparam int CFG_PEND_BIT   = 4;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_POP,
    SEL_PEEK,
    SEL_STATUS,
    SEL_CONFIG
  } reg_sel_e;

  // Map a low address byte to a register; unaligned bytes select nothing.
  function automatic reg_sel_e decode_offset(input logic [7:0] off);
    reg_sel_e sel;
    sel = SEL_NONE;
    if (off[1:0] == 2'b00) begin
      if (off >= OFF_POP_FIRST && off <= OFF_POP_LAST) sel = SEL_POP;
      else if (off == OFF_PEEK)                       sel = SEL_PEEK;
      else if (off == OFF_STATUS)                     sel = SEL_STATUS;
      else if (off == OFF_CONFIG)                     sel = SEL_CONFIG;
    end
    return sel;
  endfunction

  function automatic logic [31:0] pack_status(input logic is_full,
                                              input logic is_empty);
    logic [31:0] w;
    w = '0;
    w[STAT_FULL_BIT]  = is_full;
    w[STAT_EMPTY_BIT] = is_empty;
    return w;
  endfunction

  function automatic logic [31:0] pack_config(input logic en,
                                              input logic pend);
    logic [31:0] w;
    w = '0;
    w[CFG_EN_BIT]   = en;
    w[CFG_PEND_BIT] = pend;
    return w;
  endfunction

  // Next occupancy from current count and accepted events.
  function automatic int unsigned next_count(input int unsigned cnt,
                                             input logic push_ok,
                                             input logic pop_ok);
    return cnt + (push_ok ? 1 : 0) - (pop_ok ? 1 : 0);
  endfunction

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  output reg_sel_e          rd_sel,
  output logic              pop_req,
  output logic              cfg_wr
);

  logic     whole_word;
  reg_sel_e hit;

  assign whole_word = (req_be == 4'hF);

  always_comb begin
    hit = SEL_NONE;
    if (req_valid && whole_word) hit = decode_offset(req_addr[7:0]);
  end

  assign rd_sel  = req_write ? SEL_NONE : hit;
  assign pop_req = !req_write && (hit == SEL_POP);
  assign cfg_wr  = req_write && (hit == SEL_CONFIG);

endmodule

// File: rtl/mbx_store.sv
module mbx_store
  import mbx_pkg::*;
#(
  parameter int              DEPTH  = 8,
  parameter int              DW     = 32,
  parameter int              CNT_W  = 4,
  parameter logic [DW-1:0]   MARKER = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  input  logic [DW-1:0]    push_data,
  input  logic             pop_req,
  output logic [DW-1:0]    head_data,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty,
  output logic             push_ok,
  output logic             pop_ok
);

  logic [DW-1:0]    slot_view [DEPTH];
  logic [CNT_W-1:0] wr_idx;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push_valid && !full;
  assign pop_ok  = pop_req && !empty;

  // When a pop shifts the queue down, the tail slot moves one lower.
  assign wr_idx  = pop_ok ? count - 1'b1 : count;

  assign head_data = slot_view[0];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [DW-1:0] slot_q;
    logic [DW-1:0] shifted;

    if (i == DEPTH - 1) begin : g_tail
      assign shifted = MARKER;
    end else begin : g_body
      assign shifted = slot_view[i+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  slot_q <= MARKER;
      else if (push_ok && wr_idx == CNT_W'(i))     slot_q <= push_data;
      else if (pop_ok)                             slot_q <= shifted;
    end

    assign slot_view[i] = slot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= CNT_W'(next_count(int'(count), push_ok, pop_ok));
  end

endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [31:0] cfg_wdata,
  input  logic        empty,
  output logic        irq_en,
  output logic        pending,
  output logic        irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_en <= 1'b0;
    else if (cfg_wr) irq_en <= cfg_wdata[CFG_EN_BIT];
  end

  assign pending = !empty;
  assign irq     = pending && irq_en;

endmodule

// File: rtl/inbox_mailbox.sv
module inbox_mailbox
  import mbx_pkg::*;
#(
  parameter int          ADDR_W = 12,
  parameter int          DEPTH  = 8,
  parameter logic [31:0] MARKER = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  input  logic [31:0]       req_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  input  logic              push_valid,
  input  logic [31:0]       push_data,
  output logic              full,
  output logic              irq
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  reg_sel_e         rd_sel;
  logic             pop_req;
  logic             cfg_wr;
  logic [31:0]      head_data;
  logic [CNT_W-1:0] count;
  logic             empty;
  logic             push_ok;
  logic             pop_ok;
  logic             irq_en;
  logic             pending;
  logic [31:0]      rd_mux;

  mbx_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_be    (req_be),
    .rd_sel    (rd_sel),
    .pop_req   (pop_req),
    .cfg_wr    (cfg_wr)
  );

  mbx_store #(
    .DEPTH (DEPTH),
    .DW    (32),
    .CNT_W (CNT_W),
    .MARKER(MARKER)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_valid(push_valid),
    .push_data (push_data),
    .pop_req   (pop_req),
    .head_data (head_data),
    .count     (count),
    .full      (full),
    .empty     (empty),
    .push_ok   (push_ok),
    .pop_ok    (pop_ok)
  );

  mbx_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_wdata(req_wdata),
    .empty    (empty),
    .irq_en   (irq_en),
    .pending  (pending),
    .irq      (irq)
  );

  always_comb begin
    unique case (rd_sel)
      SEL_POP:    rd_mux = empty ? MARKER : head_data;
      SEL_PEEK:   rd_mux = head_data;
      SEL_STATUS: rd_mux = pack_status(full, empty);
      SEL_CONFIG: rd_mux = pack_config(irq_en, pending);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= req_valid && !req_write;
      rd_data  <= (req_valid && !req_write) ? rd_mux : '0;
    end
  end

endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic [3:0]       req_be,
  input logic             push_valid,
  input logic             pop_req,
  input logic             cfg_wr,
  input logic [CNT_W-1:0] count,
  input logic             full,
  input logic             empty,
  input logic             irq_en,
  input logic             irq,
  input logic             rd_valid
);

  AST_POP_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req && !empty && !push_valid |=> count == CNT_W'($past(count) - 1'b1)); // R1

  AST_EMPTY_POP_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req && empty && !push_valid |=> empty); // R2

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R4

  AST_ENABLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(irq_en)); // R5

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (irq_en && !empty)); // R6

  AST_PARTIAL_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_be != 4'hF |-> !pop_req); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    full && push_valid && !pop_req |=> full && $stable(count)); // R11

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R11

  AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write |=> rd_valid); // R12

endmodule

bind inbox_mailbox mbx_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_be    (req_be),
  .push_valid(push_valid),
  .pop_req   (pop_req),
  .cfg_wr    (cfg_wr),
  .count     (count),
  .full      (full),
  .empty     (empty),
  .irq_en    (irq_en),
  .irq       (irq),
  .rd_valid  (rd_valid)
);

// File: tb/inbox_mailbox_test.sv
module inbox_mailbox_test;

  localparam int          CLK_PERIOD = 10;
  localparam int          DEPTH      = 8;
  localparam logic [31:0] MARK       = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        push_valid = 1'b0;
  logic [31:0] push_data = '0;
  logic        full;
  logic        irq;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  inbox_mailbox uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .push_valid(push_valid), .push_data(push_data),
    .full(full), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: inputs applied after a falling edge, results sampled on the next one.
  task automatic cycle(input logic rv, input logic rw, input logic [11:0] a,
                       input logic [3:0] be, input logic [31:0] wd,
                       input logic pv, input logic [31:0] pd);
    req_valid = rv; req_write = rw; req_addr = a; req_be = be; req_wdata = wd;
    push_valid = pv; push_data = pd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; push_valid = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    cycle(1'b1, 1'b0, a, 4'hF, '0, 1'b0, '0);
    d = rd_data;
  endtask

  task automatic push(input logic [31:0] d);
    cycle(1'b0, 1'b0, '0, 4'h0, '0, 1'b1, d);
  endtask

  // Vector: op[81:80] (0 push, 1 write, 2 read), addr[79:68], be[67:64], data[63:32], expect[31:0]
  localparam int NV = 21;
  localparam logic [81:0] VEC [NV] = '{
    {2'd2, 12'h098, 4'hF, 32'h0,        32'h4000_0000}, // R4 empty status
    {2'd2, 12'h080, 4'hF, 32'h0,        32'hFFFF_FFFF}, // R2 empty pop
    {2'd2, 12'h090, 4'hF, 32'h0,        32'hFFFF_FFFF}, // R7 peek marker
    {2'd0, 12'h000, 4'h0, 32'h0000_0011, 32'h0},
    {2'd0, 12'h000, 4'h0, 32'h0000_0022, 32'h0},
    {2'd2, 12'h090, 4'hF, 32'h0,        32'h0000_0011}, // R3 peek
    {2'd2, 12'h098, 4'hF, 32'h0,        32'h0000_0000}, // R4 neither flag
    {2'd2, 12'h09C, 4'hF, 32'h0,        32'h0000_0010}, // R5 pending
    {2'd1, 12'h09C, 4'hF, 32'hFFFF_FFFF, 32'h0},        // R5 write all ones
    {2'd2, 12'h09C, 4'hF, 32'h0,        32'h0000_0011}, // R5 only bit 0 taken
    {2'd2, 12'h184, 4'hF, 32'h0,        32'h0000_0011}, // R8 alias pop
    {2'd2, 12'h088, 4'h3, 32'h0,        32'h0000_0000}, // R9 partial read
    {2'd2, 12'h090, 4'hF, 32'h0,        32'h0000_0022}, // R9 no pop happened
    {2'd2, 12'h0A0, 4'hF, 32'h0,        32'h0000_0000}, // R10 unsupported
    {2'd2, 12'h081, 4'hF, 32'h0,        32'h0000_0000}, // R10 unaligned
    {2'd1, 12'h09C, 4'h1, 32'h0,        32'h0},         // R9 partial write
    {2'd2, 12'h09C, 4'hF, 32'h0,        32'h0000_0011}, // R9 enable kept
    {2'd1, 12'h09C, 4'hF, 32'h0,        32'h0},
    {2'd2, 12'h08C, 4'hF, 32'h0,        32'h0000_0022}, // R1 pop at 0x8C
    {2'd2, 12'h09C, 4'hF, 32'h0,        32'h0000_0000}, // R5 cleared
    {2'd2, 12'h090, 4'hF, 32'h0,        32'hFFFF_FFFF}  // R7 freed slot refilled
  };
  string vreq [NV] = '{"R4","R2","R7","-","-","R3","R4","R5","-","R5","R8","R9",
                       "R9","R10","R10","-","R9","-","R1","R5","R7"};

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R7 full after reset", {31'b0, full}, 32'd0);
    check("R6 irq after reset", {31'b0, irq}, 32'd0);
    check("R12 rd_valid idle", {31'b0, rd_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      op = VEC[i][81:80];
      cycle(op != 2'd0, op == 2'd1, VEC[i][79:68], VEC[i][67:64], VEC[i][63:32],
            op == 2'd0, VEC[i][63:32]);
      if (op == 2'd2) begin
        check($sformatf("%s vector %0d", vreq[i], i), rd_data, VEC[i][31:0]);
        check($sformatf("R12 vector %0d", i), {31'b0, rd_valid}, 32'd1);
      end
    end

    // R11: fill to DEPTH, drop extra push, drain in order
    for (int i = 0; i < DEPTH; i++) push(32'hA000_0000 + i);
    check("R11 full flag", {31'b0, full}, 32'd1);
    rd(12'h098, d); check("R4 full status", d, 32'h8000_0000);
    push(32'hDEAD_BEEF);
    check("R11 still full", {31'b0, full}, 32'd1);
    // R11: pop and push together at full, push dropped
    cycle(1'b1, 1'b0, 12'h080, 4'hF, '0, 1'b1, 32'hBAD0_0000);
    check("R1 pop at full", rd_data, 32'hA000_0000);
    check("R11 not full after pop", {31'b0, full}, 32'd0);
    for (int i = 1; i < DEPTH; i++) begin
      rd(12'h084, d); check("R1 order", d, 32'hA000_0000 + i);
    end
    rd(12'h098, d); check("R11 dropped pushes absent", d, 32'h4000_0000);

    // R1: push and pop in the same cycle
    push(32'h0000_0101);
    cycle(1'b1, 1'b0, 12'h080, 4'hF, '0, 1'b1, 32'h0000_0202);
    check("R1 simultaneous pop data", rd_data, 32'h0000_0101);
    rd(12'h090, d); check("R1 simultaneous push kept", d, 32'h0000_0202);

    // R6: interrupt gating
    check("R6 irq disabled with data", {31'b0, irq}, 32'd0);
    cycle(1'b1, 1'b1, 12'h09C, 4'hF, 32'h1, 1'b0, '0);
    check("R6 irq after enable", {31'b0, irq}, 32'd1);
    rd(12'h080, d);
    check("R6 irq drops when empty", {31'b0, irq}, 32'd0);
    push(32'h0000_0303);
    check("R6 irq on push", {31'b0, irq}, 32'd1);

    // R7: reset mid-run
    push(32'h0000_0404);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R7 irq cleared", {31'b0, irq}, 32'd0);
    rd(12'h09C, d); check("R7 config cleared", d, 32'h0);
    rd(12'h090, d); check("R7 peek marker", d, MARK);
    rd(12'h098, d); check("R7 empty status", d, 32'h4000_0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule